// File: doc/BRIEF.md
# Programmable Power-of-Two Clock Divider with Dual Fanout

This block takes one reference clock and produces a set of identical output clocks, each available as a true and a complement signal. The outputs carry either the reference itself or the reference slowed down by 2, 4, 8 or 16. A three-bit mode input picks the ratio. An active-low control input serves two purposes. In the divide modes it clears the divider. In every mode it also parks the outputs: true low, complement high.

Every output change is aligned to a falling edge of the reference. Because of this, enabling or disabling a clock never produces a shortened high phase. In the divide modes, the divided clock comes from a free-running binary counter and is retimed on the falling edge, so the duty cycle is 50%. The mode input is treated as static and is changed only while the block is held disabled.

Top module: `clkdiv_fanout`

## Requirements
- R1: With modeSel[2] = 0 the block is in bypass. While enabled, every true output is high during the reference high phase and low during its low phase. The values of modeSel[1:0] make no difference.
- R2: With modeSel[2] = 1, modeSel[1:0] picks the ratio: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 16. Each output phase lasts half the ratio in reference cycles.
- R3: After rstN is released in a divide mode, the counter starts from zero. Number the falling reference edges after the release as k = 1, 2, and so on. From falling edge k onward, the true output equals bit (ratio log2 − 1) of the value k − 1.
- R4: While rstN is low, once a falling reference edge has occurred, every true output is low and every complement output is high, for any modeSel value.
- R5: Driving rstN low does not change the outputs straight away. A high output stays high until the next falling reference edge and then goes low. This holds in both bypass and divide modes.
- R6: In bypass, releasing rstN during a reference high phase does not raise the outputs in that phase. The first high output phase is the one after the next falling edge.
- R7: In divide modes, holding rstN low clears the counter at once. Each new release restarts the output sequence of R3 from k = 1, whatever count was reached before.
- R8: All output pairs carry the same clock, and each complement output is always the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low divider clear and output disable |
| modeSel | input | 3 | Mode: bit 2 chooses divide; bits 1:0 choose the ratio |
| outTrue | output | NUM_OUT | True outputs, one per pair |
| outComp | output | NUM_OUT | Complement outputs, one per pair |

## Verification
Each divide ratio is run from a fresh release and compared at every falling edge against the counter-bit formula. This separates a wrong tap, an off-by-one start and a counter that is not cleared. Bypass runs use both an all-zero and an all-one value in the low select bits, which shows whether those bits are really ignored. Disable is applied in the middle of a high phase, in both families, and the output is sampled before and after the next falling edge. This tells a correct falling-edge disable apart from an immediate one. A seeded random sequence of modes and run lengths then repeats all of these patterns in mixed order.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // number of binary stages in the divider (largest ratio is 2**DIV_STAGES)
  localparam int DIV_STAGES = 4;
  localparam int TAP_W      = $clog2(DIV_STAGES);
  localparam int MODE_W     = TAP_W + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic             bypass;   // pass the reference straight through
    logic             gateOn;   // enable, retimed on the falling edge
    logic             armNext;  // enable value to be taken at the next falling edge
    logic [TAP_W-1:0] tap;      // counter bit that forms the divided clock
  } ctrl_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic              refClk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  output ctrl_t             ctrl
);
  logic gateQ;

  // enable only changes while the reference is low, so the gate never clips a pulse
  always_ff @(negedge refClk) begin
    gateQ <= rstN;
  end

  always_comb begin
    ctrl.bypass  = ~modeSel[MODE_W-1];
    ctrl.tap     = modeSel[TAP_W-1:0];
    ctrl.gateOn  = gateQ;
    ctrl.armNext = rstN;
  end
endmodule

// File: rtl/clkdiv_datapath.sv
`timescale 1ns/1ps
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic  refClk,
  input  logic  rstN,
  input  ctrl_t ctrl,
  output logic  clkOut
);
  logic [DIV_STAGES-1:0] cnt;
  logic                  tapBit;
  logic                  divQ;

  // ripple-free binary counter, cleared at once by the control input
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + 1'b1;
  end

  always_comb tapBit = cnt[ctrl.tap];

  // retime the divided clock on the falling edge; disable lands here too
  always_ff @(negedge refClk) begin
    if (!ctrl.armNext) divQ <= 1'b0;
    else               divQ <= tapBit;
  end

  always_comb begin
    if (ctrl.bypass) clkOut = refClk & ctrl.gateOn;
    else             clkOut = divQ;
  end
endmodule

// File: rtl/clkdiv_fanout_drv.sv
`timescale 1ns/1ps
module clkdiv_fanout_drv #(
  parameter int NUM_OUT = 2
) (
  input  logic               clkIn,
  output logic [NUM_OUT-1:0] outTrue,
  output logic [NUM_OUT-1:0] outComp
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pair
    assign outTrue[i] = clkIn;
    assign outComp[i] = ~clkIn;
  end
endmodule

// File: rtl/clkdiv_fanout.sv
`timescale 1ns/1ps
module clkdiv_fanout
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic [MODE_W-1:0]  modeSel,
  output logic [NUM_OUT-1:0] outTrue,
  output logic [NUM_OUT-1:0] outComp
);
  ctrl_t ctrl;
  logic  clkMid;

  clkdiv_ctrl u_ctrl (
    .refClk  (refClk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .ctrl    (ctrl)
  );

  clkdiv_datapath u_dp (
    .refClk (refClk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .clkOut (clkMid)
  );

  clkdiv_fanout_drv #(.NUM_OUT(NUM_OUT)) u_drv (
    .clkIn   (clkMid),
    .outTrue (outTrue),
    .outComp (outComp)
  );
endmodule

// File: rtl/clkdiv_fanout_chk.sv
`timescale 1ns/1ps
module clkdiv_fanout_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input logic               refClk,
  input logic               rstN,
  input logic [MODE_W-1:0]  modeSel,
  input logic [NUM_OUT-1:0] outTrue,
  input logic [NUM_OUT-1:0] outComp
);
  localparam int RUN_W = DIV_STAGES + 2;

  logic             armed;
  logic             prevOut;
  logic [RUN_W-1:0] runLen;
  logic             seenChange;
  logic             divMode;
  logic [RUN_W-1:0] halfLen;

  always_comb begin
    divMode = modeSel[MODE_W-1];
    halfLen = RUN_W'(1) << modeSel[TAP_W-1:0];
  end

  always_ff @(negedge refClk) armed <= 1'b1;

  // length of the current output phase in reference cycles
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      prevOut    <= 1'b0;
      runLen     <= '0;
      seenChange <= 1'b0;
    end else begin
      prevOut <= outTrue[0];
      if (outTrue[0] != prevOut) begin
        runLen     <= RUN_W'(1);
        seenChange <= 1'b1;
      end else if (runLen != '1) begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  p_comp_inverse_r8: assert property (@(posedge refClk) disable iff (!rstN)
    outComp == ~outTrue);

  p_pairs_match_r8: assert property (@(posedge refClk) disable iff (!rstN)
    (outTrue == '0) || (outTrue == '1));

  p_disabled_low_r4: assert property (@(negedge refClk) disable iff (!armed)
    !rstN |=> (outTrue == '0) && (outComp == '1));

  p_bypass_high_r1: assert property (@(negedge refClk) disable iff (!rstN)
    (!divMode && $past(rstN)) |-> (outTrue == '1));

  p_div_halfperiod_r2: assert property (@(posedge refClk) disable iff (!rstN)
    (divMode && seenChange && (outTrue[0] != prevOut)) |-> (runLen == halfLen));

  p_div_nostretch_r2: assert property (@(posedge refClk) disable iff (!rstN)
    (divMode && seenChange && (outTrue[0] == prevOut)) |-> (runLen < halfLen));
endmodule

bind clkdiv_fanout clkdiv_fanout_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .refClk  (refClk),
  .rstN    (rstN),
  .modeSel (modeSel),
  .outTrue (outTrue),
  .outComp (outComp)
);

// File: tb/clkdiv_fanout_bench.sv
`timescale 1ns/1ps
module clkdiv_fanout_bench;
  localparam int NUM_OUT = 2;
  localparam int SEED    = 1234;

  logic               refClk = 1'b0;
  logic               rstN   = 1'b0;
  logic [2:0]         modeSel = 3'b111;
  logic [NUM_OUT-1:0] outTrue;
  logic [NUM_OUT-1:0] outComp;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 refClk = ~refClk;

  clkdiv_fanout #(.NUM_OUT(NUM_OUT)) u_clkdiv_fanout (
    .refClk  (refClk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .outTrue (outTrue),
    .outComp (outComp)
  );

  // expected true output after falling edge k of a divide run
  function automatic logic expDiv(int k, int idx);
    return 1'(((k - 1) >> (idx + 1 - 1)) & 1);
  endfunction

  task automatic chk(string req, logic expT);
    logic [NUM_OUT-1:0] eT;
    eT = expT ? '1 : '0;
    total++;
    if (outTrue !== eT || outComp !== ~eT) begin
      bad++;
      $display("FAIL %s t=%0t true=%b comp=%b expected true=%b comp=%b",
               req, $time, outTrue, outComp, eT, ~eT);
    end
  endtask

  task automatic runDiv(logic [1:0] ratio, int n);
    int k;
    int idx;
    idx = int'(ratio);
    @(posedge refClk); #1 modeSel = {1'b1, ratio};
    @(negedge refClk); @(negedge refClk); #1 chk("R4", 1'b0);
    @(posedge refClk); #1 rstN = 1'b1;
    k = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge refClk); #1 k = i;
      chk((i % 3 == 0) ? "R7" : ((i < 2 ** (idx + 1)) ? "R3" : "R2"), expDiv(k, idx));
    end
    while (expDiv(k, idx) != 1'b1) begin
      @(negedge refClk); #1 k++;
    end
    @(posedge refClk); #1 rstN = 1'b0;
    #0.5 chk("R5", 1'b1);
    @(negedge refClk); #1 chk("R5", 1'b0);
  endtask

  task automatic runBypass(logic [1:0] lowBits, int n);
    @(posedge refClk); #1 modeSel = {1'b0, lowBits};
    @(negedge refClk); #1 chk("R4", 1'b0);
    @(posedge refClk); #1 rstN = 1'b1;
    #0.5 chk("R6", 1'b0);
    for (int i = 0; i < n; i++) begin
      @(posedge refClk); #1 chk("R1", 1'b1);
      @(negedge refClk); #1 chk("R1", 1'b0);
    end
    @(posedge refClk); #1 rstN = 1'b0;
    #0.5 chk("R5", 1'b1);
    @(negedge refClk); #1 chk("R5", 1'b0);
    @(posedge refClk); #1 chk("R5", 1'b0);
  endtask

  initial begin
    void'($urandom(SEED));
    repeat (4) @(posedge refClk);
    #1 chk("R4", 1'b0);
    modeSel = 3'b000;
    @(negedge refClk); #1 chk("R4", 1'b0);

    // directed: every ratio, both bypass encodings
    for (int r = 0; r < 4; r++) runDiv(2'(r), 40);
    runBypass(2'b00, 6);
    runBypass(2'b11, 6);

    // seeded random modes and run lengths
    for (int it = 0; it < 16; it++) begin
      logic [2:0] m;
      int len;
      m   = 3'($urandom % 8);
      len = 10 + int'($urandom % 50);
      if (m[2]) runDiv(m[1:0], len);
      else      runBypass(m[1:0], len / 4 + 1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule